// File: doc/BRIEF.md
# Parallel Display Bus Slave (6800-style)

This block sits between an asynchronous 6800-style microprocessor bus and the internal logic of a display controller. It samples the chip-select, read/write, enable, data/command-select and 8-bit data pins in the system clock domain. Each completed bus cycle is routed to one of four places: a command byte output, a display RAM write port, a display RAM read port, or the status input. Each access is classified by the read/write and data/command-select levels. The host reads either display data or a status byte back over the same bus. The block drives the bus only while a read is in progress.

Display RAM accesses use an internal address counter that advances by one on every RAM read or RAM write, wrapping at the top of the address space. The host loads the counter by sending the address-set command byte (0x15) followed by one more command byte that carries the address. Reads are served from a one-entry prefetch register. After an address load, that register holds a dummy value, so the first RAM read returns the dummy and each later read returns the next address in order.

The main state machine has three states:
- `ST_IDLE`: waits for a strobe. It moves to `ST_ACTIVE` on a rising enable while chip select is low.
- `ST_ACTIVE`: holds the strobe phase. From here it goes back to `ST_IDLE` if chip select rises (abort) or if enable falls on a write or status read. It goes to `ST_FETCH` if enable falls on a RAM read.
- `ST_FETCH`: captures the RAM data into the prefetch register and always returns to `ST_IDLE`.

Top module: `disp_bus_slave`

## Requirements
- R1: After reset, `bus_doe`, `ram_we`, `ram_re` and `cmd_valid` are low, the RAM address is 0, and the prefetch register holds the dummy value 0x00.
- R2: An enable pulse while `bus_cs_n` is high produces no RAM access, no command, no output enable and no change of address or prefetch contents.
- R3: A write (`bus_rw_n`=0) with `bus_dc`=1 produces a one-cycle `ram_we` carrying the bus byte at the current address, then advances the address by one.
- R4: A write with `bus_dc`=0 produces a one-cycle `cmd_valid` carrying the bus byte.
- R5: A read (`bus_rw_n`=1) with `bus_dc`=0 returns `status_in` on `bus_dout`, and does not change the address or the prefetch register.
- R6: After an address load, the first RAM read (`bus_rw_n`=1, `bus_dc`=1) returns 0x00. Every later RAM read returns the RAM content at the address following the previous fetch. Each RAM read issues one `ram_re` and advances the address.
- R7: A command byte 0x15 arms address loading. The next command byte is loaded as the RAM address and empties the prefetch register to the dummy value. Both bytes still appear on `cmd_valid`.
- R8: `bus_doe` is high only while the synchronised chip select is low, read/write is high and enable is high within a started cycle. It is low during writes.
- R9: A bus cycle completes on the synchronised falling edge of enable, with exactly one single-cycle strobe per completed write or RAM read.
- R10: The RAM address wraps from 0xFF to 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_cs_n | input | 1 | Chip select, active low (asynchronous) |
| bus_rw_n | input | 1 | High for read, low for write (asynchronous) |
| bus_e | input | 1 | Enable strobe, active high (asynchronous) |
| bus_dc | input | 1 | High selects display data, low selects command/status |
| bus_din | input | 8 | Data bus input side |
| bus_dout | output | 8 | Data bus output side |
| bus_doe | output | 1 | Output enable for the bus tri-state driver |
| cmd_valid | output | 1 | One-cycle command byte strobe |
| cmd_data | output | 8 | Command byte |
| ram_we | output | 1 | Display RAM write strobe |
| ram_waddr | output | 8 | Display RAM write address |
| ram_wdata | output | 8 | Display RAM write data |
| ram_re | output | 1 | Display RAM read request, data expected one cycle later |
| ram_raddr | output | 8 | Display RAM read address |
| ram_rdata | input | 8 | Display RAM read data |
| status_in | input | 8 | Status byte returned on status reads |

## Verification
The directed patterns are:
- an address load followed by a read burst, which tells the dummy return apart from real data;
- a load at 0xFF followed by two writes, which exposes the address wrap;
- enable pulses with chip select high, which must leave every output and the next read result untouched.

Constrained-random sequences then mix RAM writes, RAM reads, status reads, plain commands and address loads. These show whether writes, reads and loads share the single address counter correctly. They also show whether a write after a prefetch wrongly refreshes the prefetched byte, and whether a stray 0x15 inside a command stream arms the loader.

// File: rtl/disp_bus_pkg.sv
package disp_bus_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_FETCH  = 2'd2
    } bus_state_t;

    typedef struct packed {
        logic       cs_n;
        logic       rw_n;
        logic       e;
        logic       dc;
        logic [7:0] data;
    } bus_smp_t;

    localparam int SMP_W = $bits(bus_smp_t);

endpackage

// File: rtl/disp_bus_sync.sv
module disp_bus_sync #(
    parameter int                 WIDTH     = 12,
    parameter int                 STAGES    = 2,
    parameter logic [WIDTH-1:0]   RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    genvar b;
    generate
        for (b = 0; b < WIDTH; b++) begin : g_bit
            logic [STAGES-1:0] chain_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain_q <= {STAGES{RESET_VAL[b]}};
                end else begin
                    chain_q <= {chain_q[STAGES-2:0], async_in[b]};
                end
            end
            assign sync_out[b] = chain_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/disp_bus_fsm.sv
module disp_bus_fsm
    import disp_bus_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  bus_smp_t smp,
    output logic     do_ram_wr,
    output logic     do_cmd_wr,
    output logic     do_ram_rd,
    output logic     fetch_cap,
    output logic     doe
);

    bus_state_t state_q, state_d;
    logic       e_prev_q;
    logic       e_fall;
    logic       e_rise;

    assign e_fall = e_prev_q & ~smp.e;
    assign e_rise = ~e_prev_q & smp.e;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            e_prev_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            e_prev_q <= smp.e;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (e_rise && !smp.cs_n) state_d = ST_ACTIVE;
            end
            ST_ACTIVE: begin
                if (smp.cs_n) begin
                    state_d = ST_IDLE;
                end else if (e_fall) begin
                    state_d = (smp.rw_n && smp.dc) ? ST_FETCH : ST_IDLE;
                end
            end
            ST_FETCH: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        do_ram_wr = 1'b0;
        do_cmd_wr = 1'b0;
        do_ram_rd = 1'b0;
        fetch_cap = 1'b0;
        doe       = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_ACTIVE: begin
                doe = smp.rw_n & ~smp.cs_n & smp.e;
                if (e_fall && !smp.cs_n) begin
                    do_ram_wr = ~smp.rw_n &  smp.dc;
                    do_cmd_wr = ~smp.rw_n & ~smp.dc;
                    do_ram_rd =  smp.rw_n &  smp.dc;
                end
            end
            ST_FETCH: fetch_cap = 1'b1;
            default: ;
        endcase
    end

    AST_WR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        do_ram_wr |=> !do_ram_wr); // R9
    AST_CMD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        do_cmd_wr |=> !do_cmd_wr); // R9
    AST_DOE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        doe |-> !do_ram_wr && !do_cmd_wr); // R8
    AST_FETCH_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_cap |-> $past(do_ram_rd)); // R6

endmodule

// File: rtl/disp_bus_dpath.sv
module disp_bus_dpath #(
    parameter int               ADDR_W    = 8,
    parameter int               DATA_W    = 8,
    parameter logic [DATA_W-1:0] ADDR_CMD = 8'h15,
    parameter logic [DATA_W-1:0] DUMMY    = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              do_ram_wr,
    input  logic              do_cmd_wr,
    input  logic              do_ram_rd,
    input  logic              fetch_cap,
    input  logic [DATA_W-1:0] bus_byte,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] rd_buf
);

    logic              arm_q;
    logic              load;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] buf_q;

    assign load = do_cmd_wr & arm_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arm_q <= 1'b0;
        end else if (do_cmd_wr) begin
            arm_q <= arm_q ? 1'b0 : (bus_byte == ADDR_CMD);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (load) begin
            addr_q <= bus_byte[ADDR_W-1:0];
        end else if (do_ram_wr || do_ram_rd) begin
            addr_q <= addr_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_q <= DUMMY;
        end else if (load) begin
            buf_q <= DUMMY;
        end else if (fetch_cap) begin
            buf_q <= ram_rdata;
        end
    end

    assign addr   = addr_q;
    assign rd_buf = buf_q;

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (do_ram_wr || do_ram_rd) |=> addr_q == $past(addr_q) + 1'b1); // R3
    AST_DUMMY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> buf_q == DUMMY); // R7
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(do_ram_wr || do_ram_rd || do_cmd_wr) |=> $stable(addr_q)); // R5

endmodule

// File: rtl/disp_bus_slave.sv
module disp_bus_slave
    import disp_bus_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_cs_n,
    input  logic              bus_rw_n,
    input  logic              bus_e,
    input  logic              bus_dc,
    input  logic [7:0]        bus_din,
    output logic [7:0]        bus_dout,
    output logic              bus_doe,
    output logic              cmd_valid,
    output logic [7:0]        cmd_data,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_waddr,
    output logic [7:0]        ram_wdata,
    output logic              ram_re,
    output logic [ADDR_W-1:0] ram_raddr,
    input  logic [7:0]        ram_rdata,
    input  logic [7:0]        status_in
);

    localparam logic [SMP_W-1:0] SMP_RST = {1'b1, 1'b1, 1'b0, 1'b0, 8'h00};

    bus_smp_t          smp;
    logic [SMP_W-1:0]  smp_bits;
    logic              do_ram_wr, do_cmd_wr, do_ram_rd, fetch_cap, doe;
    logic [ADDR_W-1:0] addr;
    logic [7:0]        rd_buf;

    disp_bus_sync #(.WIDTH(SMP_W), .STAGES(2), .RESET_VAL(SMP_RST)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({bus_cs_n, bus_rw_n, bus_e, bus_dc, bus_din}),
        .sync_out (smp_bits)
    );

    assign smp = bus_smp_t'(smp_bits);

    disp_bus_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp       (smp),
        .do_ram_wr (do_ram_wr),
        .do_cmd_wr (do_cmd_wr),
        .do_ram_rd (do_ram_rd),
        .fetch_cap (fetch_cap),
        .doe       (doe)
    );

    disp_bus_dpath #(.ADDR_W(ADDR_W), .DATA_W(8)) u_dpath (
        .clk       (clk),
        .rst_n     (rst_n),
        .do_ram_wr (do_ram_wr),
        .do_cmd_wr (do_cmd_wr),
        .do_ram_rd (do_ram_rd),
        .fetch_cap (fetch_cap),
        .bus_byte  (smp.data),
        .ram_rdata (ram_rdata),
        .addr      (addr),
        .rd_buf    (rd_buf)
    );

    assign bus_doe   = doe;
    assign bus_dout  = smp.dc ? rd_buf : status_in;
    assign cmd_valid = do_cmd_wr;
    assign cmd_data  = smp.data;
    assign ram_we    = do_ram_wr;
    assign ram_wdata = smp.data;
    assign ram_waddr = addr;
    assign ram_re    = do_ram_rd;
    assign ram_raddr = addr;

    AST_NO_DRIVE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        bus_doe |-> !smp.cs_n && smp.rw_n); // R8
    AST_NO_SIMUL_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        !(ram_we && ram_re)); // R9

endmodule

// File: tb/sim_disp_bus_slave.sv
module sim_disp_bus_slave;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_cs_n = 1'b1, bus_rw_n = 1'b1, bus_e = 1'b0, bus_dc = 1'b0;
    logic [7:0] bus_din = 8'h00;
    logic [7:0] bus_dout, cmd_data, ram_wdata, ram_rdata, status_in;
    logic [7:0] ram_waddr, ram_raddr;
    logic       bus_doe, cmd_valid, ram_we, ram_re;

    int checks = 0;
    int errors = 0;
    int we_cnt = 0, cmd_cnt = 0, re_cnt = 0;
    logic [7:0] last_wa, last_wd, last_cmd;
    logic [7:0] resp_mem [256];
    logic [7:0] ref_mem [256];
    logic [7:0] exp_addr = 8'h00;
    logic [7:0] exp_buf  = 8'h00;
    logic       exp_arm  = 1'b0;
    logic       done = 1'b0;

    always #5 clk = ~clk;

    disp_bus_slave u0 (
        .clk(clk), .rst_n(rst_n), .bus_cs_n(bus_cs_n), .bus_rw_n(bus_rw_n),
        .bus_e(bus_e), .bus_dc(bus_dc), .bus_din(bus_din), .bus_dout(bus_dout),
        .bus_doe(bus_doe), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
        .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata),
        .ram_re(ram_re), .ram_raddr(ram_raddr), .ram_rdata(ram_rdata),
        .status_in(status_in)
    );

    always @(posedge clk) begin
        if (ram_re) begin
            ram_rdata <= resp_mem[ram_raddr];
            re_cnt    <= re_cnt + 1;
        end
        if (ram_we) begin
            resp_mem[ram_waddr] <= ram_wdata;
            we_cnt  <= we_cnt + 1;
            last_wa <= ram_waddr;
            last_wd <= ram_wdata;
        end
        if (cmd_valid) begin
            cmd_cnt  <= cmd_cnt + 1;
            last_cmd <= cmd_data;
        end
    end

    function automatic logic [7:0] pattern(input int i);
        return 8'(i) ^ 8'h5A;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One bus cycle; rd_val holds bus_dout sampled while E is high.
    task automatic bus_cycle(input logic cs_n, input logic rw_n, input logic dc,
                             input logic [7:0] d, output logic [7:0] rd_val,
                             output logic oe_seen);
        @(negedge clk);
        bus_cs_n = cs_n; bus_rw_n = rw_n; bus_dc = dc; bus_din = d;
        repeat (2) @(negedge clk);
        bus_e = 1'b1;
        repeat (5) @(negedge clk);
        rd_val  = bus_dout;
        oe_seen = bus_doe;
        bus_e = 1'b0;
        repeat (8) @(negedge clk);
        bus_cs_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic ram_write(input logic [7:0] d);
        logic [7:0] v; logic oe; int w0;
        w0 = we_cnt;
        bus_cycle(1'b0, 1'b0, 1'b1, d, v, oe);
        check("R3 we count", we_cnt - w0, 1);
        check("R3 waddr", last_wa, exp_addr);
        check("R3 wdata", last_wd, d);
        check("R8 oe low on write", oe, 0);
        ref_mem[exp_addr] = d;
        exp_addr = exp_addr + 1;
    endtask

    task automatic ram_read();
        logic [7:0] v; logic oe; int r0;
        r0 = re_cnt;
        bus_cycle(1'b0, 1'b1, 1'b1, 8'h00, v, oe);
        check("R6 read data", v, exp_buf);
        check("R8 oe on read", oe, 1);
        check("R9 one fetch", re_cnt - r0, 1);
        exp_buf  = ref_mem[exp_addr];
        exp_addr = exp_addr + 1;
    endtask

    task automatic cmd_write(input logic [7:0] d);
        logic [7:0] v; logic oe; int c0;
        c0 = cmd_cnt;
        bus_cycle(1'b0, 1'b0, 1'b0, d, v, oe);
        check("R4 cmd count", cmd_cnt - c0, 1);
        check("R4 cmd data", last_cmd, d);
        if (exp_arm) begin
            exp_addr = d; exp_buf = 8'h00; exp_arm = 1'b0;
        end else begin
            exp_arm = (d == 8'h15);
        end
    endtask

    task automatic status_read();
        logic [7:0] v; logic oe; logic [7:0] s;
        s = 8'($urandom);
        status_in = s;
        bus_cycle(1'b0, 1'b1, 1'b0, 8'h00, v, oe);
        check("R5 status", v, s);
        check("R8 oe on status", oe, 1);
    endtask

    task automatic set_addr(input logic [7:0] a);
        if (exp_arm) cmd_write(8'h00); // consume a stray arm
        cmd_write(8'h15);
        cmd_write(a);
    endtask

    task automatic ignored_cycle(input logic rw_n, input logic dc);
        logic [7:0] v; logic oe; int w0, c0, r0;
        w0 = we_cnt; c0 = cmd_cnt; r0 = re_cnt;
        bus_cycle(1'b1, rw_n, dc, 8'($urandom), v, oe);
        check("R2 no oe", oe, 0);
        check("R2 no access", (we_cnt - w0) + (cmd_cnt - c0) + (re_cnt - r0), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 256; i++) begin
            resp_mem[i] = pattern(i);
            ref_mem[i]  = pattern(i);
        end
        status_in = 8'h00;
        ram_rdata = 8'h00;
        repeat (3) @(negedge clk);
        check("R1 doe", bus_doe, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R1 strobes", {bus_doe, ram_we, ram_re, cmd_valid}, 0);
        // R1: reset address 0 and dummy buffer, seen through a read
        ram_read();
        ram_read();
        // R7/R6: load then burst
        set_addr(8'h40);
        for (int k = 0; k < 4; k++) ram_read();
        // R10: wrap
        set_addr(8'hFF);
        ram_write(8'hA1);
        ram_write(8'hB2);
        check("R10 wrapped waddr", last_wa, 8'h00);
        // R2: ignored cycles between reads
        set_addr(8'h10);
        ram_read();
        ignored_cycle(1'b1, 1'b1);
        ignored_cycle(1'b0, 1'b1);
        ignored_cycle(1'b0, 1'b0);
        ram_read();
        // R5: status does not disturb the stream
        status_read();
        ram_read();
        // random mix
        for (int n = 0; n < 300; n++) begin
            int op;
            op = int'($urandom_range(0, 9));
            case (op)
                0, 1, 2: ram_write(8'($urandom));
                3, 4, 5: ram_read();
                6:       status_read();
                7:       cmd_write(($urandom_range(0, 3) == 0) ? 8'h15 : 8'($urandom));
                8:       set_addr(8'($urandom));
                default: ignored_cycle(1'($urandom), 1'($urandom));
            endcase
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule